// File: doc/BRIEF.md
# Read-Only Register Target on a Two-Wire Serial Bus

This block lets a bus controller read a small, read-only register space over a standard I2C two-wire bus. It runs entirely from a fast system clock: SCL and SDA are brought in through synchronisers and a short glitch filter, and the block finds bus conditions and clock edges by oversampling. It responds to a single fixed 7-bit address, takes one register-pointer byte on a write, and on a read shifts out register bytes until the controller declines one.

Register contents are not stored here. Each time a byte is needed the block raises a one-cycle read request with the register index. The neighbouring register bank returns the byte one clock later. The pointer steps through the seven registers and wraps from the last one back to the first. The pointer is forgotten at every STOP, so a controller reads a chosen register with a pointer write, a repeated START and a read. SDA is never driven high: the block only pulls it low or releases it. SCL is only sampled and is never held low.

Top module: `i2c_ro_target`

## Requirements
- R1: During and right after reset, SDA is released (sda_oe = 0) and no read request is issued.
- R2: The address bytes 0xAA (target 0x55, write) and 0xAB (target 0x55, read) are acknowledged. SDA is held low for the whole high phase of the ninth SCL pulse.
- R3: An address byte carrying any other 7-bit address gets no acknowledge. SDA stays released until the next START.
- R4: After a write address, one pointer byte is acknowledged. A value 0 to 6 selects that register. Any value above 6 selects register 0.
- R5: A further byte written after the pointer byte in the same transfer is not acknowledged.
- R6: Read data leaves most significant bit first. The level driven on SDA changes only while SCL is low.
- R7: Each byte fetched for a read uses the current pointer, which then advances 0,1,…,6,0. A controller acknowledge fetches the next byte in the burst.
- R8: On a controller NAK the block releases SDA and issues no further read request until a new START.
- R9: A STOP clears the pointer to 0 and releases SDA. A repeated START leaves the pointer unchanged.
- R10: rd_req is a single-cycle pulse with rd_addr in 0..6. The bank presents the byte on rd_data one clock after rd_req, where the block samples it.
- R11: A pulse on SCL or SDA shorter than the filter length (3 clocks by default) has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_req | output | 1 | One-cycle request for a register byte |
| rd_addr | output | 3 | Register index for the request |
| rd_data | input | 8 | Byte from the register bank, valid one clock after rd_req |

## Verification
The properties assume a well-formed controller. It changes SDA only while SCL is low, except to form START and STOP. It never starts or stops a transfer while the target drives SDA. Each SCL phase is much longer than the synchroniser and filter latency, so the target has settled on SDA before SCL rises. The stimulus uses a quarter-bit spacing of 12 clocks, well above the roughly seven-clock path from pin to SDA enable. Glitches are injected only as single-clock pulses inside stable phases, below the filter length.

// File: rtl/i2c_ro_pkg.sv
package i2c_ro_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_PTR,
    PH_PTR_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

endpackage

// File: rtl/i2c_ro_filter.sv
module i2c_ro_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   out_q, out_d;

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (sync_q[SYNC_STAGES-1] == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      out_d = ~out_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/i2c_ro_cond.sv
module i2c_ro_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/i2c_ro_engine.sv
module i2c_ro_engine
  import i2c_ro_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h55,
  parameter int         NREGS    = 7,
  parameter int         PW       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              rd_req,
  output logic [PW-1:0]     rd_addr
);
  localparam int LAST = NREGS - 1;

  phase_t            st_q, st_d;
  logic              rw_q, rw_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [PW-1:0]     ptr_q, ptr_d, addr_q, addr_d;
  logic              oe_q, oe_d, req_q, req_d, ld_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(LAST)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    st_d   = st_q;
    rw_d   = rw_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    addr_d = addr_q;
    oe_d   = oe_q;
    req_d  = 1'b0;
    if (ld_q) sh_d = rd_data;
    if (stop_ev) begin
      st_d  = PH_IDLE;
      ptr_d = '0;
      oe_d  = 1'b0;
    end else if (start_ev) begin
      st_d  = PH_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        PH_ADDR, PH_PTR: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (st_q == PH_PTR) begin
              oe_d  = 1'b1;
              st_d  = PH_PTR_ACK;
              ptr_d = (int'(sh_q) > LAST) ? '0 : sh_q[PW-1:0];
            end else if (sh_q[7:1] == DEV_ADDR) begin
              oe_d = 1'b1;
              st_d = PH_ADDR_ACK;
              rw_d = sh_q[0];
              if (sh_q[0]) begin
                req_d  = 1'b1;
                addr_d = ptr_q;
                ptr_d  = step(ptr_q);
              end
            end else begin
              st_d = PH_IDLE;
            end
          end
        end
        PH_ADDR_ACK: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            st_d = PH_TX;
            oe_d = ~sh_q[7];
          end else begin
            st_d = PH_PTR;
            oe_d = 1'b0;
          end
        end
        PH_PTR_ACK: if (scl_fall) begin
          st_d = PH_IDLE;
          oe_d = 1'b0;
        end
        PH_TX: if (scl_fall) begin
          if (cnt_q == 4'd7) begin
            oe_d = 1'b0;
            st_d = PH_MACK;
          end else begin
            sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
            oe_d  = ~sh_q[6];
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            if (!sda_f) begin
              req_d  = 1'b1;
              addr_d = ptr_q;
              ptr_d  = step(ptr_q);
            end else begin
              st_d = PH_IDLE;
            end
          end else if (scl_fall) begin
            st_d  = PH_TX;
            cnt_d = '0;
            oe_d  = ~sh_q[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      rw_q   <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      addr_q <= '0;
      oe_q   <= 1'b0;
      req_q  <= 1'b0;
      ld_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      rw_q   <= rw_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      addr_q <= addr_d;
      oe_q   <= oe_d;
      req_q  <= req_d;
      ld_q   <= req_q;
    end
  end

  assign sda_oe  = oe_q;
  assign rd_req  = req_q;
  assign rd_addr = addr_q;
endmodule

// File: rtl/i2c_ro_target.sv
module i2c_ro_target
  import i2c_ro_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h55,
  parameter int         NREGS       = 7,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  localparam int        PW          = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              rd_req,
  output logic [PW-1:0]     rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  logic [1:0] raw, filt;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_ro_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]), .line_o(filt[g])
    );
  end

  assign scl_f = filt[1];
  assign sda_f = filt[0];

  i2c_ro_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_ro_engine #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS), .PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_f(sda_f), .rd_data(rd_data),
    .sda_oe(sda_oe), .rd_req(rd_req), .rd_addr(rd_addr)
  );
endmodule

// File: rtl/i2c_ro_checks.sv
module i2c_ro_checks #(
  parameter int NREGS = 7,
  localparam int PW = $clog2(NREGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          sda_oe,
  input logic          rd_req,
  input logic [PW-1:0] rd_addr
);
  localparam int LAST = NREGS - 1;

  logic          chain_q;
  logic [PW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= 1'b0;
      last_q  <= '0;
    end else if (start_ev || stop_ev) begin
      chain_q <= 1'b0;
    end else if (rd_req) begin
      chain_q <= 1'b1;
      last_q  <= rd_addr;
    end
  end

  // R10: request lasts one cycle
  p_rdreq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R10: index stays inside the register space
  p_rdaddr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (int'(rd_addr) <= LAST));

  // R6: SDA enable only moves while filtered SCL is low
  p_sda_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  // R7: successive fetches within one read follow the wrapping order
  p_burst_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && chain_q) |->
      (rd_addr == ((int'(last_q) == LAST) ? PW'(0) : PW'(last_q + 1'b1))));

  // R9: STOP leaves the line released
  p_release_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

bind i2c_ro_target i2c_ro_checks #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe), .rd_req(rd_req), .rd_addr(rd_addr)
);

// File: tb/sim_i2c_ro_target.sv
module sim_i2c_ro_target;
  localparam int Q = 12;

  logic       clk, rst_n, scl_m, sda_m;
  logic       sda_oe, rd_req;
  logic [2:0] rd_addr;
  logic [7:0] rd_data, bank_q;
  logic       sda_line;
  int         n_chk, n_fail, n_req, n_oe;
  bit         done;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = bank_q;

  i2c_ro_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mk(input int a);
    return 8'h5A ^ 8'(a * 37);
  endfunction

  function automatic int nx(input int a);
    return (a == 6) ? 0 : a + 1;
  endfunction

  always @(posedge clk) begin
    if (rd_req) bank_q <= mk(int'(rd_addr));
    if (rd_req) n_req <= n_req + 1;
    if (sda_oe) n_oe <= n_oe + 1;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
  endtask

  // one bit: returns line level early and late in the SCL high phase
  task automatic clk_bit(input logic b, input bit glitch,
                         output logic s_a, output logic s_b);
    wq(Q);
    if (glitch) begin scl_m = 1'b1; wq(1); scl_m = 1'b0; end
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(1); s_a = sda_line;
    if (glitch && b) begin wq(Q - 2); sda_m = 1'b0; wq(1); sda_m = 1'b1; wq(Q - 3); end
    else wq(2 * Q - 4);
    s_b = sda_line; wq(2);
    scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v, input bit glitch, output bit ack);
    logic a, b;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], glitch, a, b);
    clk_bit(1'b1, 1'b0, a, b);
    ack = (a == 1'b0) && (b == 1'b0);
  endtask

  task automatic rd_byte(input logic nak, output logic [7:0] v, output bit steady);
    logic a, b;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, a, b);
      v[i] = b;
      if (a !== b) steady = 1'b0;
    end
    clk_bit(nak, 1'b0, a, b);
  endtask

  // pointer write, repeated START, read of n bytes
  task automatic rand_read(input logic [7:0] p, input int n, input int first);
    bit ack, st; logic [7:0] v; int e;
    bus_start();
    wr_byte(8'hAA, 1'b0, ack); check("R2 write address ack", ack, 1);
    wr_byte(p, 1'b0, ack);     check("R4 pointer ack", ack, 1);
    bus_rstart();
    wr_byte(8'hAB, 1'b0, ack); check("R2 read address ack", ack, 1);
    e = first;
    for (int k = 0; k < n; k++) begin
      rd_byte((k == n - 1), v, st);
      check("R7 burst data", v, mk(e));
      check("R6 steady SDA in high phase", st, 1);
      e = nx(e);
    end
    bus_stop();
  endtask

  initial begin
    bit ack, st; logic [7:0] v; int r0, o0;
    logic a, b;
    n_chk = 0; n_fail = 0; n_req = 0; n_oe = 0; done = 0; bank_q = '0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    wq(5);
    check("R1 sda released in reset", sda_oe, 0);
    check("R1 no request in reset", rd_req, 0);
    rst_n = 1'b1; wq(5);
    check("R1 sda released after reset", sda_oe, 0);
    check("R1 no request after reset", n_req, 0);

    // R4 R7: every legal pointer, plus out-of-range values
    for (int p = 0; p < 7; p++) rand_read(8'(p), 2, p);
    rand_read(8'd7, 1, 0);
    rand_read(8'd200, 1, 0);
    // R7: long burst across the wrap
    rand_read(8'd4, 10, 4);

    // R9: STOP discards the pointer
    bus_start(); wr_byte(8'hAA, 1'b0, ack); wr_byte(8'd5, 1'b0, ack); bus_stop();
    bus_start(); wr_byte(8'hAB, 1'b0, ack); check("R9 read after stop ack", ack, 1);
    rd_byte(1'b1, v, st); check("R9 pointer cleared by stop", v, mk(0));
    bus_stop();

    // R9 R8: repeated START keeps the advanced pointer; NAK stops fetching
    bus_start(); wr_byte(8'hAA, 1'b0, ack); wr_byte(8'd2, 1'b0, ack);
    bus_rstart(); wr_byte(8'hAB, 1'b0, ack);
    rd_byte(1'b1, v, st); check("R9 first byte", v, mk(2));
    r0 = n_req; o0 = n_oe;
    for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, a, b);
    check("R8 no fetch after NAK", n_req, r0);
    check("R8 SDA released after NAK", n_oe, o0);
    bus_rstart(); wr_byte(8'hAB, 1'b0, ack);
    rd_byte(1'b1, v, st); check("R9 pointer kept over repeated start", v, mk(3));
    bus_stop();

    // R5: extra write byte
    bus_start(); wr_byte(8'hAA, 1'b0, ack); wr_byte(8'd1, 1'b0, ack);
    wr_byte(8'h33, 1'b0, ack); check("R5 extra byte not acked", ack, 0);
    bus_stop();

    // R11: glitches on both lines during the whole exchange
    bus_start(); wr_byte(8'hAA, 1'b1, ack); check("R11 glitched address ack", ack, 1);
    wr_byte(8'd3, 1'b1, ack); check("R11 glitched pointer ack", ack, 1);
    bus_rstart(); wr_byte(8'hAB, 1'b1, ack); check("R11 glitched read ack", ack, 1);
    rd_byte(1'b1, v, st); check("R11 data after glitches", v, mk(3));
    bus_stop();

    // R3: every other address, then one more byte of clocks
    for (int ad = 0; ad < 128; ad++) begin
      if (ad == 'h55) continue;
      o0 = n_oe; r0 = n_req;
      bus_start();
      wr_byte({7'(ad), 1'(ad)}, 1'b0, ack);
      for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, a, b);
      check("R3 foreign address ignored", (n_oe - o0) + (n_req - r0), 0);
      bus_stop();
    end
    check("R9 released at end", sda_oe, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule